// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into one raw status vector. Two outputs share it: a normal interrupt line and a fast interrupt line. Each output has its own enable mask, and the line is raised whenever any raw source that its mask enables is high. Neither mask is written directly. Software sets mask bits by writing ones to a set word and clears them by writing ones to a clear word. Other bits of the mask therefore never need a read-modify-write.

Source 0 is shared with a software trigger. Software can raise a sticky soft bit and later lower it. Raw bit 0 is the OR of hardware input 0 and that soft bit, so lowering the soft bit never hides a hardware request. Hardware sources are not latched: the raw bits follow the inputs. Both outputs are registered, so they reflect the raw and mask state one clock later. An output may drive a source input of another instance.

The register bus is a simple one. The word index and the write strobe are sampled on the rising clock edge. Read data is a combinational function of the word index and the current state.

Top module: `dual_irq_ctl`

## Requirements
- R1: While reset is low and after it is released, both masks and the soft bit are zero and both outputs are low.
- R2: A write to word 2 ORs the write data into the normal mask. A read of word 2 returns the normal mask.
- R3: A write to word 3 clears every normal-mask bit that is set in the write data and leaves the other bits unchanged.
- R4: Words 10 and 11 act on the fast mask in the same way: a write to word 10 sets bits, a write to word 11 clears bits, and a read of word 10 returns the fast mask.
- R5: Reads of word 1 and word 9 both return the raw vector. The raw vector is the hardware source levels, with the soft bit ORed into bit 0, and it has no latching.
- R6: A read of word 0 returns the raw vector AND the normal mask. A read of word 8 returns the raw vector AND the fast mask.
- R7: A write to word 4 with data bit 0 set raises the soft bit. A write to word 5 with data bit 0 set lowers it. Such a write with data bit 0 clear has no effect. A read of word 4 returns raw bit 0 in bit 0, with all other bits zero.
- R8: Lowering the soft bit leaves raw bit 0 high while hardware input 0 is high.
- R9: The normal output is high in the cycle after the raw vector AND the normal mask is nonzero, and low otherwise. The fast output follows the same rule with the fast mask.
- R10: Reads of words 3, 5 and 11, and of every word that is not listed above, return zero. Writes to words 0, 1, 8 and 9, and to unlisted words, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_word | input | 6 | Word index of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| src_lvl | input | 32 | Hardware interrupt source levels |
| irq_o | output | 1 | Normal interrupt output, registered |
| fiq_o | output | 1 | Fast interrupt output, registered |

## Verification
The bench writes to each mask's set and clear words with overlapping bit patterns. A design that wrote the mask directly, or that cleared bits it should keep, would then read back the wrong mask. The bench lowers the soft bit while hardware input 0 is high. A design that let the soft clear hide the hardware level would read raw bit 0 as zero and drop its output. The bench writes to the read-only words and to unmapped words, and reads the write-only words. A decoder with loose address compares would change a mask or return stale data. A free-running random phase checks the output timing on every clock against a model. A design whose outputs were combinational, or lagged by two clocks, would fail that comparison.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int W_NRM_STAT = 0;
  localparam int W_RAW_A    = 1;
  localparam int W_MASK_SET = 2;
  localparam int W_MASK_CLR = 3;
  localparam int W_SOFT_SET = 4;
  localparam int W_SOFT_CLR = 5;
  localparam int W_FST_STAT = 8;
  localparam int W_RAW_B    = 9;
  localparam int CH_STRIDE  = 8;
  localparam int N_CH       = 2;

  function automatic int set_word(input int ch);
    return W_MASK_SET + ch * CH_STRIDE;
  endfunction

  function automatic int clr_word(input int ch);
    return W_MASK_CLR + ch * CH_STRIDE;
  endfunction

  function automatic logic [31:0] mask_next(input logic [31:0] cur,
                                            input logic set_en,
                                            input logic clr_en,
                                            input logic [31:0] d);
    logic [31:0] r;
    r = cur;
    if (set_en) r = r | d;
    if (clr_en) r = r & ~d;
    return r;
  endfunction
endpackage

// File: rtl/dirq_mask_reg.sv
module dirq_mask_reg #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] mask_o
);
  import dirq_pkg::*;

  logic [31:0] nxt_full;
  always_comb begin
    nxt_full = mask_next(32'(mask_o), set_we_i, clr_we_i, 32'(data_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= nxt_full[NSRC-1:0];
  end

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we_i && !clr_we_i) |=> ((mask_o & $past(data_i)) == $past(data_i)));
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> ((mask_o & $past(data_i)) == '0));
  a_r3_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> ((mask_o & ~$past(data_i)) == ($past(mask_o) & ~$past(data_i))));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we_i && !clr_we_i) |=> $stable(mask_o));
endmodule

// File: rtl/dirq_raw_src.sv
module dirq_raw_src #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_set_i,
  input  logic            soft_clr_i,
  input  logic [NSRC-1:0] src_lvl_i,
  output logic [NSRC-1:0] raw_o
);
  logic soft_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          soft_q <= 1'b0;
    else if (soft_set_i) soft_q <= 1'b1;
    else if (soft_clr_i) soft_q <= 1'b0;
  end

  always_comb begin
    raw_o    = src_lvl_i;
    raw_o[0] = src_lvl_i[0] | soft_q;
  end

  a_r7_soft_raises: assert property (@(posedge clk) disable iff (!rst_n)
    soft_set_i |=> raw_o[0]);
  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    src_lvl_i[0] |-> raw_o[0]);
  a_r5_upper_follow: assert property (@(posedge clk) disable iff (!rst_n)
    raw_o[NSRC-1] == src_lvl_i[NSRC-1]);
endmodule

// File: rtl/dirq_rd_mux.sv
module dirq_rd_mux #(
  parameter int NSRC   = 32,
  parameter int WORD_W = 6
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [NSRC-1:0]   raw_i,
  input  logic [NSRC-1:0]   nrm_mask_i,
  input  logic [NSRC-1:0]   fst_mask_i,
  output logic [NSRC-1:0]   rdata_o
);
  import dirq_pkg::*;

  always_comb begin
    rdata_o = '0;
    if (word_i == WORD_W'(W_NRM_STAT))       rdata_o = raw_i & nrm_mask_i;
    else if (word_i == WORD_W'(W_RAW_A))     rdata_o = raw_i;
    else if (word_i == WORD_W'(set_word(0))) rdata_o = nrm_mask_i;
    else if (word_i == WORD_W'(W_SOFT_SET))  rdata_o[0] = raw_i[0];
    else if (word_i == WORD_W'(W_FST_STAT))  rdata_o = raw_i & fst_mask_i;
    else if (word_i == WORD_W'(W_RAW_B))     rdata_o = raw_i;
    else if (word_i == WORD_W'(set_word(1))) rdata_o = fst_mask_i;
  end
endmodule

// File: rtl/dual_irq_ctl.sv
module dual_irq_ctl #(
  parameter int NSRC   = 32,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              irq_o,
  output logic              fiq_o
);
  import dirq_pkg::*;

  logic [NSRC-1:0] raw;
  logic            soft_set_ev;
  logic            soft_clr_ev;
  logic [N_CH-1:0] set_ev;
  logic [N_CH-1:0] clr_ev;
  logic [N_CH-1:0] hit;
  logic [N_CH-1:0] out_q;
  logic [NSRC-1:0] mask [N_CH];

  assign soft_set_ev = bus_we && bus_word == WORD_W'(W_SOFT_SET) && bus_wdata[0];
  assign soft_clr_ev = bus_we && bus_word == WORD_W'(W_SOFT_CLR) && bus_wdata[0];

  dirq_raw_src #(.NSRC(NSRC)) u_raw (
    .clk(clk), .rst_n(rst_n),
    .soft_set_i(soft_set_ev), .soft_clr_i(soft_clr_ev),
    .src_lvl_i(src_lvl), .raw_o(raw)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign set_ev[ch] = bus_we && bus_word == WORD_W'(set_word(ch));
    assign clr_ev[ch] = bus_we && bus_word == WORD_W'(clr_word(ch));

    dirq_mask_reg #(.NSRC(NSRC)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_we_i(set_ev[ch]), .clr_we_i(clr_ev[ch]),
      .data_i(bus_wdata), .mask_o(mask[ch])
    );

    assign hit[ch] = |(raw & mask[ch]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[ch] <= 1'b0;
      else        out_q[ch] <= hit[ch];
    end

    a_r9_out_rises: assert property (@(posedge clk) disable iff (!rst_n)
      hit[ch] |=> out_q[ch]);
    a_r9_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[ch] |=> !out_q[ch]);
  end

  dirq_rd_mux #(.NSRC(NSRC), .WORD_W(WORD_W)) u_rd (
    .word_i(bus_word), .raw_i(raw),
    .nrm_mask_i(mask[0]), .fst_mask_i(mask[1]),
    .rdata_o(bus_rdata)
  );

  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];

  a_r7_soft_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(soft_set_ev && soft_clr_ev));
  a_r10_one_mask_op: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_ev, clr_ev}) <= 1);
endmodule

// File: tb/dual_irq_ctl_test.sv
module dual_irq_ctl_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_lvl = '0;
  logic        irq_o, fiq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  dual_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference
  bit [31:0] m_ie = 0, m_fe = 0;
  bit        m_soft = 0, m_irq = 0, m_fiq = 0;

  function automatic bit [31:0] m_raw();
    return src_lvl | {31'b0, m_soft};
  endfunction

  function automatic bit [31:0] m_read(input int w);
    bit [31:0] r = m_raw();
    case (w)
      0: return r & m_ie;
      1, 9: return r;
      2: return m_ie;
      4: return {31'b0, r[0]};
      8: return r & m_fe;
      10: return m_fe;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      0, 8: return "R6";
      1, 9: return "R5";
      2: return "R2";
      10: return "R4";
      4: return "R7";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie <= 0; m_fe <= 0; m_soft <= 0; m_irq <= 0; m_fiq <= 0;
    end else begin
      m_irq <= (m_raw() & m_ie) != 0;
      m_fiq <= (m_raw() & m_fe) != 0;
      if (bus_we) begin
        case (int'(bus_word))
          2: m_ie <= m_ie | bus_wdata;
          3: m_ie <= m_ie & ~bus_wdata;
          10: m_fe <= m_fe | bus_wdata;
          11: m_fe <= m_fe & ~bus_wdata;
          4: if (bus_wdata[0]) m_soft <= 1;
          5: if (bus_wdata[0]) m_soft <= 0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (!done) begin
      chk(rst_n ? "R9" : "R1", {31'b0, irq_o}, {31'b0, m_irq});
      chk(rst_n ? "R9" : "R1", {31'b0, fiq_o}, {31'b0, m_fiq});
      chk(rst_n ? tag_of(int'(bus_word)) : "R1", bus_rdata, m_read(int'(bus_word)));
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_word = 6'(w); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic peek(input int w, input string req, input logic [31:0] exp);
    @(negedge clk);
    bus_word = 6'(w);
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    peek(2, "R1", 0);
    peek(10, "R1", 0);
    rst_n = 1;
    peek(2, "R1", 0);
    chk("R1", {31'b0, irq_o}, 0);

    // R2 / R3 normal mask
    wr(2, 32'h0000_00F0);
    wr(2, 32'h0000_0F00);
    peek(2, "R2", 32'h0000_0FF0);
    wr(3, 32'h0000_0330);
    peek(2, "R3", 32'h0000_0CC0);

    // R4 fast mask
    wr(10, 32'h8000_0001);
    wr(11, 32'h0000_0001);
    peek(10, "R4", 32'h8000_0000);

    // R5 / R6 / R9 sources
    @(negedge clk); src_lvl = 32'h8000_0040;
    peek(1, "R5", 32'h8000_0040);
    peek(0, "R6", 32'h0000_0040);
    peek(8, "R6", 32'h8000_0000);
    @(negedge clk);
    chk("R9", {30'b0, irq_o, fiq_o}, 2'b11);
    @(negedge clk); src_lvl = 0;
    @(negedge clk);
    chk("R9", {30'b0, irq_o, fiq_o}, 2'b00);

    // R7 soft bit
    wr(4, 32'hFFFF_FFFE);
    peek(4, "R7", 0);
    wr(4, 32'h1);
    peek(4, "R7", 1);
    peek(9, "R7", 1);
    wr(5, 32'h1);
    peek(4, "R7", 0);

    // R8 hardware keeps bit 0
    @(negedge clk); src_lvl = 32'h1;
    wr(4, 32'h1);
    wr(5, 32'h1);
    peek(1, "R8", 32'h1);
    @(negedge clk); src_lvl = 0;

    // R10 ignored writes and zero reads
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    wr(40, 32'hFFFF_FFFF);
    peek(2, "R10", 32'h0000_0CC0);
    peek(10, "R10", 32'h8000_0000);
    peek(4, "R10", 0);
    peek(3, "R10", 0);
    peek(5, "R10", 0);
    peek(11, "R10", 0);
    peek(63, "R10", 0);

    // random traffic checked each cycle against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      bus_we = $urandom_range(0, 1) == 1;
      bus_word = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(12, 63))
                                             : 6'($urandom_range(0, 11));
      bus_wdata = $urandom();
      if ($urandom_range(0, 3) == 0) src_lvl = $urandom() & $urandom();
    end
    @(negedge clk); bus_we = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule